// File: doc/BRIEF.md
# Indirect Register Access Command Engine

This block gives a host a way to reach targets that do not sit in its own address map. The host has two write locations: a 32-bit extension register, which holds data, and a command register. A write to the command register starts one bus cycle on the target that the command names. The target is one of three: a small bank of local indirect registers on an internal bus, a control memory port, or an external PHY device. The PHY device uses the memory address and data lines, and it has its own active-low chip-enable, output-enable and read/write strobes.

For a write, the host first loads the extension register with the data and then issues the command. For a read, the host issues the command, polls `busy` until it drops or waits for `done`, and then reads `ext_q`, which now holds the returned data. The PHY data path is 8 bits wide and uses the low byte lanes. Every target access lasts a fixed number of cycles, and each target has its own parameter for that length.

The host port is a plain register-write port with no back-pressure. There is no ready signal. A write that arrives while `busy` is high is dropped with no effect. The host must therefore use `busy` or `done` as its flow control. No streaming data interface is present.

Top module: `ind_access_engine`

## Requirements
- R1: After reset, `busy`, `done`, `cm_req` and `cm_we` are 0, `ext_q` is 0, and `phy_ce_n`, `phy_oe_n` and `phy_rw_n` are 1.
- R2: The command word has the write flag at bit 31 (1 = write), the target code at bits 20:19 and the address at bits 18:0. Bits 30:21 are ignored. Target 00 selects control memory and 01 selects the local indirect registers. Codes 10 and 11 both select the PHY path and behave identically.
- R3: A control memory write drives `cm_req`=1, `cm_we`=1, `cm_addr`=address and `cm_wdata`=`ext_q` for every cycle of its window. `ext_q` keeps the staged data afterwards.
- R4: A control memory read drives `cm_req`=1 and `cm_we`=0 with `cm_addr`=address. At completion, `ext_q` takes the `cm_rdata` value present on the last cycle of the window.
- R5: A command write accepted while idle sets `busy` on that clock edge and clears `done`. `busy` stays high for exactly CM_WAIT, IAR_WAIT or PHY_WAIT cycles, according to the target. On the edge where `busy` falls, `done` becomes 1 and stays 1 until the next command is accepted.
- R6: While `busy` is high, writes to both the command register and the extension register are ignored. The running access and `ext_q` are unaffected, and no second access follows.
- R7: A local indirect register write stores `ext_q` into entry address[log2(IAR_DEPTH)-1:0]. A read of that entry later returns the full 32 bits. These accesses leave every external strobe inactive and keep `cm_addr` and `cm_wdata` at 0.
- R8: A PHY write holds `phy_ce_n`=0, `phy_rw_n`=0 and `phy_oe_n`=1 for the window. It drives `cm_addr`=address and `cm_wdata`={24'b0, `ext_q`[7:0]}, and `cm_req` stays 0.
- R9: A PHY read holds `phy_ce_n`=0, `phy_oe_n`=0 and `phy_rw_n`=1 for the window. At completion, `ext_q` becomes {24'b0, `cm_rdata`[7:0]}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_we | input | 1 | Host register write strobe |
| host_sel | input | 1 | 0 selects the extension register, 1 selects the command register |
| host_wdata | input | 32 | Host write data |
| ext_q | output | 32 | Extension register contents |
| busy | output | 1 | Access in progress |
| done | output | 1 | Last command has completed |
| cm_req | output | 1 | Control memory cycle active |
| cm_we | output | 1 | Control memory write |
| cm_addr | output | 19 | Shared address lines (memory and PHY) |
| cm_wdata | output | 32 | Shared write data lines |
| cm_rdata | input | 32 | Shared read data lines |
| phy_ce_n | output | 1 | PHY chip enable, active low |
| phy_oe_n | output | 1 | PHY output enable, active low |
| phy_rw_n | output | 1 | PHY write strobe, active low (high means read) |

## Verification
Suppose the latched command were corrupted during a window, for example by a busy-time command write that is not blocked. The target strobes or the address would then change within the same window. The bench compares every window cycle against the expected signature, so this shows up within one cycle. A wrong wait counter shows up as a window of the wrong length on `busy`. A wrong lane or a wrong capture shows up in `ext_q` at the first sample after `busy` falls. Entries of the indirect register bank are checked by reading them back, so a decode error there appears one command later.

// File: rtl/iae_pkg.sv
package iae_pkg;
  localparam int ADDR_W   = 19;
  localparam int DATA_W   = 32;
  localparam int PHY_W    = 8;
  localparam int ADDR_LSB = 0;
  localparam int TGT_LSB  = 19;
  localparam int WR_BIT   = 31;

  typedef enum logic [1:0] {
    TGT_CMEM  = 2'b00,
    TGT_IAR   = 2'b01,
    TGT_PHY_A = 2'b10,
    TGT_PHY_B = 2'b11
  } tgt_e;

  typedef struct packed {
    logic              wr;
    tgt_e              tgt;
    logic [ADDR_W-1:0] addr;
  } cmd_t;

  function automatic cmd_t unpack_cmd(input logic [DATA_W-1:0] w);
    cmd_t c;
    c.wr   = w[WR_BIT];
    c.tgt  = tgt_e'(w[TGT_LSB +: 2]);
    c.addr = w[ADDR_LSB +: ADDR_W];
    return c;
  endfunction

  function automatic logic tgt_is_phy(input tgt_e t);
    return t[1];
  endfunction
endpackage

// File: rtl/iae_seq.sv
module iae_seq
  import iae_pkg::*;
#(
  parameter int CM_WAIT  = 3,
  parameter int IAR_WAIT = 1,
  parameter int PHY_WAIT = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  cmd_t cmd_in,
  output logic busy,
  output logic done,
  output logic finish,
  output cmd_t cmd_q
);
  localparam int MAXW_A = (CM_WAIT > IAR_WAIT) ? CM_WAIT : IAR_WAIT;
  localparam int MAXW   = (MAXW_A > PHY_WAIT) ? MAXW_A : PHY_WAIT;
  localparam int CW     = $clog2(MAXW + 1);

  logic [CW-1:0] cnt;

  function automatic int wait_of(input tgt_e t);
    case (t)
      TGT_CMEM: return CM_WAIT;
      TGT_IAR:  return IAR_WAIT;
      default:  return PHY_WAIT;
    endcase
  endfunction

  assign finish = busy && (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      done  <= 1'b0;
      cnt   <= '0;
      cmd_q <= '0;
    end else if (!busy) begin
      if (start) begin
        busy  <= 1'b1;
        done  <= 1'b0;
        cmd_q <= cmd_in;
        cnt   <= CW'(wait_of(cmd_in.tgt) - 1);
      end
    end else if (cnt == '0) begin
      busy <= 1'b0;
      done <= 1'b1;
    end else begin
      cnt <= cnt - 1'b1;
    end
  end

  // R6: the latched command cannot move while an access runs
  p_cmd_frozen_r6: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(cmd_q));
  // R5: completion flag accompanies the end of every window
  p_done_on_fall_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);
  // R5: an idle start opens a window and clears the old completion
  p_start_opens_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start) |=> (busy && !done));
endmodule

// File: rtl/iae_iar_bank.sv
module iae_iar_bank #(
  parameter int DEPTH = 8,
  parameter int DW    = 32,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] idx,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] rd_vec [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_entry
    logic [DW-1:0] q;
    always_ff @(posedge clk) begin
      if (!rst_n)                        q <= '0;
      else if (we && (int'(idx) == i))   q <= wdata;
    end
    assign rd_vec[i] = q;
  end

  always_comb begin
    rdata = '0;
    if (int'(idx) < DEPTH) rdata = rd_vec[idx];
  end
endmodule

// File: rtl/iae_port_drive.sv
module iae_port_drive
  import iae_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              busy,
  input  logic              finish,
  input  cmd_t              cmd_q,
  input  logic [DATA_W-1:0] ext_q,
  input  logic [DATA_W-1:0] iar_rdata,
  input  logic [DATA_W-1:0] cm_rdata,
  output logic              cm_req,
  output logic              cm_we,
  output logic [ADDR_W-1:0] cm_addr,
  output logic [DATA_W-1:0] cm_wdata,
  output logic              phy_ce_n,
  output logic              phy_oe_n,
  output logic              phy_rw_n,
  output logic              iar_we,
  output logic [DATA_W-1:0] rd_data
);
  logic is_cm, is_iar, is_phy;

  always_comb begin
    is_cm  = busy && (cmd_q.tgt == TGT_CMEM);
    is_iar = busy && (cmd_q.tgt == TGT_IAR);
    is_phy = busy && tgt_is_phy(cmd_q.tgt);

    cm_req   = is_cm;
    cm_we    = is_cm && cmd_q.wr;
    phy_ce_n = !is_phy;
    phy_oe_n = !(is_phy && !cmd_q.wr);
    phy_rw_n = !(is_phy && cmd_q.wr);
    cm_addr  = (is_cm || is_phy) ? cmd_q.addr : '0;

    cm_wdata = '0;
    if (cmd_q.wr) begin
      if (is_cm)  cm_wdata = ext_q;
      if (is_phy) cm_wdata = {{(DATA_W-PHY_W){1'b0}}, ext_q[PHY_W-1:0]};
    end

    iar_we = finish && is_iar && cmd_q.wr;

    case (cmd_q.tgt)
      TGT_CMEM: rd_data = cm_rdata;
      TGT_IAR:  rd_data = iar_rdata;
      default:  rd_data = {{(DATA_W-PHY_W){1'b0}}, cm_rdata[PHY_W-1:0]};
    endcase
  end

  // R2: memory cycle and PHY cycle never overlap
  p_one_target_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(cm_req && !phy_ce_n));
  // R9: output enable only inside a selected PHY read
  p_phy_read_strobes_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !phy_oe_n |-> (!phy_ce_n && phy_rw_n));
  // R8: narrow PHY writes keep the upper lanes quiet
  p_phy_lanes_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !phy_rw_n |-> (cm_wdata[DATA_W-1:PHY_W] == '0));
  // R1: no strobe outside a window
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (phy_ce_n && phy_oe_n && phy_rw_n && !cm_req && !cm_we));
endmodule

// File: rtl/ind_access_engine.sv
module ind_access_engine
  import iae_pkg::*;
#(
  parameter int CM_WAIT   = 3,
  parameter int IAR_WAIT  = 1,
  parameter int PHY_WAIT  = 4,
  parameter int IAR_DEPTH = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        host_we,
  input  logic        host_sel,
  input  logic [31:0] host_wdata,
  output logic [31:0] ext_q,
  output logic        busy,
  output logic        done,
  output logic        cm_req,
  output logic        cm_we,
  output logic [18:0] cm_addr,
  output logic [31:0] cm_wdata,
  input  logic [31:0] cm_rdata,
  output logic        phy_ce_n,
  output logic        phy_oe_n,
  output logic        phy_rw_n
);
  localparam int IAW = (IAR_DEPTH > 1) ? $clog2(IAR_DEPTH) : 1;

  cmd_t              cmd_q;
  logic              finish;
  logic              iar_we;
  logic [DATA_W-1:0] iar_rdata;
  logic [DATA_W-1:0] rd_data;
  logic              start;
  logic              ext_wr;

  assign start  = host_we && host_sel;
  assign ext_wr = host_we && !host_sel && !busy;

  iae_seq #(
    .CM_WAIT (CM_WAIT),
    .IAR_WAIT(IAR_WAIT),
    .PHY_WAIT(PHY_WAIT)
  ) u_seq (
    .clk   (clk),
    .rst_n (rst_n),
    .start (start),
    .cmd_in(unpack_cmd(host_wdata)),
    .busy  (busy),
    .done  (done),
    .finish(finish),
    .cmd_q (cmd_q)
  );

  iae_iar_bank #(
    .DEPTH(IAR_DEPTH),
    .DW   (DATA_W)
  ) u_iar (
    .clk  (clk),
    .rst_n(rst_n),
    .we   (iar_we),
    .idx  (cmd_q.addr[IAW-1:0]),
    .wdata(ext_q),
    .rdata(iar_rdata)
  );

  iae_port_drive u_drv (
    .clk      (clk),
    .rst_n    (rst_n),
    .busy     (busy),
    .finish   (finish),
    .cmd_q    (cmd_q),
    .ext_q    (ext_q),
    .iar_rdata(iar_rdata),
    .cm_rdata (cm_rdata),
    .cm_req   (cm_req),
    .cm_we    (cm_we),
    .cm_addr  (cm_addr),
    .cm_wdata (cm_wdata),
    .phy_ce_n (phy_ce_n),
    .phy_oe_n (phy_oe_n),
    .phy_rw_n (phy_rw_n),
    .iar_we   (iar_we),
    .rd_data  (rd_data)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)                      ext_q <= '0;
    else if (finish && !cmd_q.wr)    ext_q <= rd_data;
    else if (ext_wr)                 ext_q <= host_wdata;
  end

  // R6: host data writes cannot disturb a running access
  p_ext_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !finish) |=> $stable(ext_q));
  // R3: a write command never alters the staged data at completion
  p_write_keeps_ext_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (finish && cmd_q.wr) |=> $stable(ext_q));
endmodule

// File: tb/ind_access_engine_test.sv
`timescale 1ns/1ps
module ind_access_engine_test;
  localparam int CMW = 3, IAW = 1, PHW = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_we = 1'b0, host_sel = 1'b0;
  logic [31:0] host_wdata = '0;
  logic [31:0] ext_q, cm_wdata, cm_rdata;
  logic        busy, done, cm_req, cm_we, phy_ce_n, phy_oe_n, phy_rw_n;
  logic [18:0] cm_addr;

  int checks = 0, failures = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  // memory / PHY model: data is a fixed function of the address lines
  assign cm_rdata = 32'hA500_0000 ^ {13'h0, cm_addr};

  ind_access_engine #(.CM_WAIT(CMW), .IAR_WAIT(IAW), .PHY_WAIT(PHW), .IAR_DEPTH(8)) uut (
    .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_sel(host_sel),
    .host_wdata(host_wdata), .ext_q(ext_q), .busy(busy), .done(done),
    .cm_req(cm_req), .cm_we(cm_we), .cm_addr(cm_addr), .cm_wdata(cm_wdata),
    .cm_rdata(cm_rdata), .phy_ce_n(phy_ce_n), .phy_oe_n(phy_oe_n), .phy_rw_n(phy_rw_n));

  typedef struct {
    logic [4:0]  strb;   // {req, we, ce_n, oe_n, rw_n}
    logic [18:0] addr;
    logic [31:0] wdata;
    int          len;
    logic [31:0] ext;
  } exp_t;

  exp_t  exp_q[$];
  string tag_q[$];

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] expv);
    checks++;
    if (act !== expv) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  task automatic finish_up();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  // ---------------- monitor ----------------
  bit          in_win = 0;
  int          win_len = 0;
  bit          sig_bad = 0;
  logic [55:0] sig_act, sig_exp;
  exp_t        cur;
  string       cur_tag;

  always @(negedge clk) begin
    if (rst_n) begin
      if (busy) begin
        if (!in_win) begin
          in_win = 1; win_len = 0; sig_bad = 0;
          if (exp_q.size() == 0) begin
            checks++; failures++;
            $display("FAIL R6 unexpected access actual=window expected=none");
            cur = '{strb: 5'b0, addr: '0, wdata: '0, len: 0, ext: '0};
            cur_tag = "R6";
          end else begin
            cur = exp_q.pop_front();
            cur_tag = tag_q.pop_front();
          end
        end
        win_len++;
        if (!sig_bad && ({cm_req, cm_we, phy_ce_n, phy_oe_n, phy_rw_n, cm_addr, cm_wdata}
                         !== {cur.strb, cur.addr, cur.wdata})) begin
          sig_bad = 1;
          sig_act = {cm_req, cm_we, phy_ce_n, phy_oe_n, phy_rw_n, cm_addr, cm_wdata};
          sig_exp = {cur.strb, cur.addr, cur.wdata};
        end
      end else if (in_win) begin
        in_win = 0;
        check({cur_tag, " bus signature"}, sig_bad ? 64'(sig_act) : 64'(sig_exp), 64'(sig_exp));
        check("R5 window length", 64'(win_len), 64'(cur.len));
        check("R5 done after window", 64'(done), 64'd1);
        check({cur_tag, " ext_q result"}, 64'(ext_q), 64'(cur.ext));
      end
    end
  end

  // ---------------- driver ----------------
  task automatic host_write(input logic sel, input logic [31:0] d);
    host_we = 1'b1; host_sel = sel; host_wdata = d;
    @(negedge clk);
    host_we = 1'b0; host_sel = 1'b0; host_wdata = '0;
  endtask

  function automatic exp_t make_exp(input bit wr, input logic [1:0] tgt,
                                    input logic [18:0] a, input logic [31:0] d,
                                    input logic [31:0] e);
    exp_t x;
    x.strb  = {tgt == 2'b00, (tgt == 2'b00) && wr, !tgt[1], !(tgt[1] && !wr), !(tgt[1] && wr)};
    x.addr  = (tgt == 2'b01) ? 19'h0 : a;
    x.wdata = !wr ? 32'h0 : (tgt == 2'b00) ? d : tgt[1] ? {24'h0, d[7:0]} : 32'h0;
    x.len   = (tgt == 2'b00) ? CMW : (tgt == 2'b01) ? IAW : PHW;
    x.ext   = e;
    return x;
  endfunction

  function automatic logic [31:0] cmd_word(input bit wr, input logic [9:0] rsv,
                                           input logic [1:0] tgt, input logic [18:0] a);
    return {wr, rsv, tgt, a};
  endfunction

  task automatic wait_idle();
    do @(negedge clk); while (busy);
  endtask

  task automatic run_cmd(input string tag, input bit wr, input logic [1:0] tgt,
                         input logic [18:0] a, input logic [9:0] rsv,
                         input logic [31:0] d, input logic [31:0] e);
    if (wr) host_write(1'b0, d);
    exp_q.push_back(make_exp(wr, tgt, a, d, e));
    tag_q.push_back(tag);
    host_write(1'b1, cmd_word(wr, rsv, tgt, a));
    wait_idle();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_up();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 busy/done", {62'h0, busy, done}, 64'h0);
    check("R1 ext_q", 64'(ext_q), 64'h0);
    check("R1 strobes", {59'h0, cm_req, cm_we, phy_ce_n, phy_oe_n, phy_rw_n}, 64'b00111);
    rst_n = 1'b1;
    @(negedge clk);

    // R3: control memory write
    run_cmd("R3", 1, 2'b00, 19'h12345, 10'h0, 32'hDEAD_BEEF, 32'hDEAD_BEEF);
    // R4: control memory read
    run_cmd("R4", 0, 2'b00, 19'h00ABC, 10'h0, 32'h0, 32'hA500_0ABC);
    // R2: reserved bits set are ignored
    run_cmd("R2", 0, 2'b00, 19'h7FFFF, 10'h3FF, 32'h0, 32'hA507_FFFF ^ 32'h0);
    // R7: indirect register bank write/read, upper address bits do not matter
    run_cmd("R7", 1, 2'b01, 19'h7FFF5, 10'h0, 32'h0BAD_F00D, 32'h0BAD_F00D);
    run_cmd("R7", 1, 2'b01, 19'h00002, 10'h0, 32'h1357_2468, 32'h1357_2468);
    run_cmd("R7", 0, 2'b01, 19'h00005, 10'h0, 32'h0, 32'h0BAD_F00D);
    run_cmd("R7", 0, 2'b01, 19'h00002, 10'h0, 32'h0, 32'h1357_2468);
    // R8: PHY write, code 10, ext keeps full word
    run_cmd("R8", 1, 2'b10, 19'h40001, 10'h0, 32'hCAFE_12C3, 32'hCAFE_12C3);
    // R9: PHY read, code 11, then code 10 (R2 alias)
    run_cmd("R9", 0, 2'b11, 19'h00F0F, 10'h0, 32'h0, 32'h0000_000F);
    run_cmd("R2", 0, 2'b10, 19'h00F0F, 10'h0, 32'h0, 32'h0000_000F);
    run_cmd("R8", 1, 2'b11, 19'h00077, 10'h155, 32'h0000_00A5, 32'h0000_00A5);

    // R5: done set now, cleared and busy set by the next accept
    check("R5 done held", 64'(done), 64'd1);
    host_write(1'b0, 32'h5555_AAAA);
    exp_q.push_back(make_exp(1, 2'b00, 19'h00100, 32'h5555_AAAA, 32'h5555_AAAA));
    tag_q.push_back("R5");
    host_write(1'b1, cmd_word(1, 10'h0, 2'b00, 19'h00100));
    check("R5 accept edge", {62'h0, busy, done}, 64'b10);
    wait_idle();

    // R6: writes during a window are ignored
    host_write(1'b0, 32'h1111_0000);
    exp_q.push_back(make_exp(1, 2'b00, 19'h00200, 32'h1111_0000, 32'h1111_0000));
    tag_q.push_back("R6");
    host_write(1'b1, cmd_word(1, 10'h0, 2'b00, 19'h00200));
    host_write(1'b0, 32'h2222_0000);
    host_write(1'b1, cmd_word(0, 10'h0, 2'b01, 19'h00005));
    wait_idle();
    repeat (2) @(negedge clk);
    check("R6 no second access", 64'(busy), 64'd0);
    check("R6 ext_q untouched", 64'(ext_q), 64'h1111_0000);
    check("R6 queue drained", 64'(exp_q.size()), 64'd0);

    finish_up();
  end
endmodule